// File: doc/BRIEF.md
# Synchronous Flash Command Front End

This block sits directly behind the pin sampling registers of a synchronous flash device whose bus borrows the command encoding of an SDRAM. Each rising clock edge it looks at chip select, the row and column strobes, write enable, the bank bits and the address bus. It turns them into a registered one-hot command pulse and captures the fields that belong to that command: the bank, the row, the column and the command code. It also keeps the mode register.

Two slots of the SDRAM command set are given new meanings. The precharge slot closes the open row of one bank, or of all banks. The refresh slot loads a command code into the flash command machinery, and it can be switched off so that it decodes as nothing.

The block keeps a flag for each bank that records whether a row is open. It refuses reads, writes and burst stops that target a closed bank. It also refuses writes that arrive before the program-setup sequence has finished, and mode loads that arrive too soon after the previous one. The data mask pin drives the write data enable in the same cycle, and drives the read output enable two clocks later.

Top module: `sfl_cmd_front`

## Requirements
- R1: While reset is asserted and just after it is released, all command strobes and error pulses are 0, every bank is closed, the read output enable is 0, and the mode register holds the MODE_DEFAULT parameter.
- R2: With clock enable high and chip select low, the code {row strobe, column strobe, write enable} decodes as follows: 111 no-op, 011 activate, 101 read, 100 write, 110 burst stop, 010 row terminate, 001 command load, 000 mode load. The strobe bits of `cmd_strobe` are 0 activate, 1 read, 2 write, 3 burst stop, 4 row terminate, 5 command load and 6 mode load. The strobe appears for one cycle after the sampling edge, and at most one bit is ever high.
- R3: When clock enable is low or chip select is high, no strobe fires, no error pulse fires and no bank flag, field or mode bit changes.
- R4: Activate sets the open flag of the bank given by the bank bits. It captures that bank, and it captures the row from the low 12 address bits (11 bits when WIDE_DATA is 1).
- R5: Read, write and burst stop to a closed bank produce no strobe and pulse `illegal_cmd`. To an open bank they strobe and capture the bank; read and write also capture the column from address bits 7:0.
- R6: A write while `prog_setup_done` is low produces no write strobe and pulses `wr_reject`.
- R7: Row terminate always strobes. With address bit 10 low it closes only the bank named by the bank bits. With bit 10 high it closes every bank, whatever the bank bits are.
- R8: Command load strobes and captures the code from address bits 7:0 while `cmd_load_en` is high. While `cmd_load_en` is low it acts as a no-op.
- R9: Mode load writes address bits 10:0 into the mode register. A load that comes fewer than MRD_GAP cycles after the last accepted load is ignored and pulses `mrd_err`.
- R10: `dq_wr_en` is the inverse of the data mask in the same cycle.
- R11: `dq_rd_oe` is the inverse of the data mask as sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable for command decode |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus |
| dqm | input | 1 | Data mask |
| cmd_load_en | input | 1 | Enables the command-load decode |
| prog_setup_done | input | 1 | Program-setup sequence has completed |
| cmd_strobe | output | 7 | One-hot registered command pulse |
| illegal_cmd | output | 1 | Access to a closed bank was refused |
| wr_reject | output | 1 | Write refused for lack of program setup |
| mrd_err | output | 1 | Mode load refused for spacing |
| bank_open | output | 4 | Open-row flag per bank |
| mode_reg | output | 11 | Mode register |
| out_bank | output | 2 | Captured bank |
| out_row | output | 12 | Captured row |
| out_col | output | 8 | Captured column |
| out_code | output | 8 | Captured command code |
| dq_wr_en | output | 1 | Write data enable |
| dq_rd_oe | output | 1 | Read output enable |

## Verification
The hardest situation to reach from the ports is a read, write or burst stop whose bank is closed while other banks are open. The same applies to a write that is refused for both reasons at once, with each combination of program-setup and command-load enable. The sweep reaches these cases by walking all sixteen pin codes in order, once per bank rotation, under every setting of clock enable, program setup and command-load enable. Because the bank bits rotate against the command order, an activate usually opens a different bank from the one the next read targets. A terminate with address bit 10 set then closes all banks at intervals. Back-to-back mode loads are driven in a separate directed step to hit the spacing limit.

// File: rtl/sfl_cmd_pkg.sv
package sfl_cmd_pkg;

   typedef enum logic [2:0] {
      K_NOP  = 3'd0,
      K_ACT  = 3'd1,
      K_RD   = 3'd2,
      K_WR   = 3'd3,
      K_BST  = 3'd4,
      K_TERM = 3'd5,
      K_LCR  = 3'd6,
      K_LMR  = 3'd7
   } cmd_kind_t;

   localparam int S_ACT       = 0;
   localparam int S_RD        = 1;
   localparam int S_WR        = 2;
   localparam int S_BST       = 3;
   localparam int S_TERM      = 4;
   localparam int S_LCR       = 5;
   localparam int S_LMR       = 6;
   localparam int NUM_STROBES = 7;

   localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/sfl_pin_decode.sv
module sfl_pin_decode
   import sfl_cmd_pkg::*;
(
   input  logic      cke,
   input  logic      cs_n,
   input  logic      ras_n,
   input  logic      cas_n,
   input  logic      we_n,
   input  logic      cmd_load_en,
   output cmd_kind_t kind
);

   always_comb begin
      kind = K_NOP;
      if (cke && !cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b111: kind = K_NOP;
            3'b011: kind = K_ACT;
            3'b101: kind = K_RD;
            3'b100: kind = K_WR;
            3'b110: kind = K_BST;
            3'b010: kind = K_TERM;
            3'b001: kind = cmd_load_en ? K_LCR : K_NOP;
            3'b000: kind = K_LMR;
            default: kind = K_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sfl_bank_tracker.sv
module sfl_bank_tracker #(
   parameter int NUM_BANKS = 4,
   localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 open_req,
   input  logic                 close_one,
   input  logic                 close_all,
   input  logic [BANK_W-1:0]    bank,
   output logic [NUM_BANKS-1:0] open_flags
);

   generate
      if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
         $error("sfl_bank_tracker: NUM_BANKS must be a power of two, at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
         logic hit;
         assign hit = (bank == BANK_W'(gi));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   open_flags[gi] <= 1'b0;
            else if (close_all)           open_flags[gi] <= 1'b0;
            else if (close_one && hit)    open_flags[gi] <= 1'b0;
            else if (open_req && hit)     open_flags[gi] <= 1'b1;
         end
      end
   endgenerate

   a_r7_close_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
      close_all |=> (open_flags == '0));

   a_r4_activate_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (open_req && !close_all && !close_one) |=> open_flags[$past(bank)]);

   a_r7_single_close: assert property (@(posedge clk) disable iff (!rst_n)
      (close_one && !open_req) |=> !open_flags[$past(bank)]);

endmodule

// File: rtl/sfl_mode_reg.sv
module sfl_mode_reg #(
   parameter int          MODE_W       = 11,
   parameter int          MRD_GAP      = 2,
   parameter logic [MODE_W-1:0] MODE_DEFAULT = '0,
   localparam int CNT_W = $clog2(MRD_GAP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_req,
   input  logic [MODE_W-1:0] load_val,
   output logic              load_ok,
   output logic              load_early,
   output logic [MODE_W-1:0] mode
);

   localparam logic [CNT_W-1:0] READY = CNT_W'(MRD_GAP - 1);

   generate
      if (MRD_GAP < 1) begin : g_bad_gap
         $error("sfl_mode_reg: MRD_GAP must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] gap_cnt;

   assign load_ok    = load_req && (gap_cnt >= READY);
   assign load_early = load_req && (gap_cnt <  READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= READY;
         mode    <= MODE_DEFAULT;
      end else if (load_ok) begin
         gap_cnt <= '0;
         mode    <= load_val;
      end else if (gap_cnt < READY) begin
         gap_cnt <= gap_cnt + 1'b1;
      end
   end

   a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_ok |=> $stable(mode));

   a_r9_mode_takes: assert property (@(posedge clk) disable iff (!rst_n)
      load_ok |=> (mode == $past(load_val)));

   generate
      if (MRD_GAP >= 2) begin : g_spacing_chk
         a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
            load_ok |=> !load_ok);
      end
   endgenerate

endmodule

// File: rtl/sfl_dqm_pipe.sv
module sfl_dqm_pipe #(
   parameter int RD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dqm,
   output logic dq_wr_en,
   output logic dq_rd_oe
);

   generate
      if (RD_LAT < 1) begin : g_bad_lat
         $error("sfl_dqm_pipe: RD_LAT must be at least 1");
      end
   endgenerate

   logic [RD_LAT-1:0] mask_sr;

   assign dq_wr_en = ~dqm;

   generate
      if (RD_LAT == 1) begin : g_lat1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_sr <= '1;
            else        mask_sr <= dqm;
         end
      end else begin : g_latn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_sr <= '1;
            else        mask_sr <= {mask_sr[RD_LAT-2:0], dqm};
         end
      end
   endgenerate

   assign dq_rd_oe = ~mask_sr[RD_LAT-1];

   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         warm <= '0;
      else if (warm != 2'd3) warm <= warm + 1'b1;
   end

   generate
      if (RD_LAT == 2) begin : g_lat_chk
         a_r11_read_oe_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (warm >= 2'd2) |-> (dq_rd_oe == !$past(dqm, 2)));
      end
   endgenerate

   a_r1_oe_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd0) |-> !dq_rd_oe);

endmodule

// File: rtl/sfl_cmd_front.sv
module sfl_cmd_front
   import sfl_cmd_pkg::*;
#(
   parameter bit          WIDE_DATA    = 1'b0,
   parameter int          NUM_BANKS    = 4,
   parameter int          ADDR_W       = 12,
   parameter int          COL_W        = 8,
   parameter int          CODE_W       = 8,
   parameter int          MODE_W       = 11,
   parameter int          MRD_GAP      = 2,
   parameter int          RD_LAT       = 2,
   parameter logic [10:0] MODE_DEFAULT = 11'h023,
   localparam int BANK_W = $clog2(NUM_BANKS),
   localparam int ROW_W  = WIDE_DATA ? 11 : 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cke,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BANK_W-1:0]      ba,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   dqm,
   input  logic                   cmd_load_en,
   input  logic                   prog_setup_done,
   output logic [NUM_STROBES-1:0] cmd_strobe,
   output logic                   illegal_cmd,
   output logic                   wr_reject,
   output logic                   mrd_err,
   output logic [NUM_BANKS-1:0]   bank_open,
   output logic [MODE_W-1:0]      mode_reg,
   output logic [BANK_W-1:0]      out_bank,
   output logic [ROW_W-1:0]       out_row,
   output logic [COL_W-1:0]       out_col,
   output logic [CODE_W-1:0]      out_code,
   output logic                   dq_wr_en,
   output logic                   dq_rd_oe
);

   generate
      if (ADDR_W < ROW_W || ADDR_W < MODE_W || ADDR_W <= ALL_BANK_BIT) begin : g_bad_addr
         $error("sfl_cmd_front: ADDR_W too narrow for row, mode or all-bank bit");
      end
      if (COL_W > ADDR_W || CODE_W > ADDR_W) begin : g_bad_fields
         $error("sfl_cmd_front: column or code field wider than the address bus");
      end
      if (MODE_W > 11) begin : g_bad_mode
         $error("sfl_cmd_front: MODE_W exceeds the default value width");
      end
   endgenerate

   cmd_kind_t kind;

   sfl_pin_decode u_decode (
      .cke         (cke),
      .cs_n        (cs_n),
      .ras_n       (ras_n),
      .cas_n       (cas_n),
      .we_n        (we_n),
      .cmd_load_en (cmd_load_en),
      .kind        (kind)
   );

   logic target_open;
   assign target_open = bank_open[ba];

   logic act_go, rd_go, wr_go, bst_go, term_go, lcr_go;
   logic rd_bad, wr_bad_bank, wr_bad_setup, bst_bad;
   logic lmr_req, lmr_ok, lmr_early;

   always_comb begin
      act_go       = (kind == K_ACT);
      rd_go        = (kind == K_RD)  &&  target_open;
      rd_bad       = (kind == K_RD)  && !target_open;
      wr_go        = (kind == K_WR)  &&  target_open && prog_setup_done;
      wr_bad_bank  = (kind == K_WR)  && !target_open;
      wr_bad_setup = (kind == K_WR)  && !prog_setup_done;
      bst_go       = (kind == K_BST) &&  target_open;
      bst_bad      = (kind == K_BST) && !target_open;
      term_go      = (kind == K_TERM);
      lcr_go       = (kind == K_LCR);
      lmr_req      = (kind == K_LMR);
   end

   sfl_bank_tracker #(
      .NUM_BANKS (NUM_BANKS)
   ) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .open_req   (act_go),
      .close_one  (term_go && !addr[ALL_BANK_BIT]),
      .close_all  (term_go &&  addr[ALL_BANK_BIT]),
      .bank       (ba),
      .open_flags (bank_open)
   );

   sfl_mode_reg #(
      .MODE_W       (MODE_W),
      .MRD_GAP      (MRD_GAP),
      .MODE_DEFAULT (MODE_DEFAULT[MODE_W-1:0])
   ) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_req   (lmr_req),
      .load_val   (addr[MODE_W-1:0]),
      .load_ok    (lmr_ok),
      .load_early (lmr_early),
      .mode       (mode_reg)
   );

   sfl_dqm_pipe #(
      .RD_LAT (RD_LAT)
   ) u_dqm (
      .clk      (clk),
      .rst_n    (rst_n),
      .dqm      (dqm),
      .dq_wr_en (dq_wr_en),
      .dq_rd_oe (dq_rd_oe)
   );

   logic [NUM_STROBES-1:0] strobe_d;
   always_comb begin
      strobe_d         = '0;
      strobe_d[S_ACT]  = act_go;
      strobe_d[S_RD]   = rd_go;
      strobe_d[S_WR]   = wr_go;
      strobe_d[S_BST]  = bst_go;
      strobe_d[S_TERM] = term_go;
      strobe_d[S_LCR]  = lcr_go;
      strobe_d[S_LMR]  = lmr_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_strobe  <= '0;
         illegal_cmd <= 1'b0;
         wr_reject   <= 1'b0;
         mrd_err     <= 1'b0;
      end else begin
         cmd_strobe  <= strobe_d;
         illegal_cmd <= rd_bad || wr_bad_bank || bst_bad;
         wr_reject   <= wr_bad_setup;
         mrd_err     <= lmr_early;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_bank <= '0;
         out_row  <= '0;
         out_col  <= '0;
         out_code <= '0;
      end else begin
         if (act_go || rd_go || wr_go || bst_go) out_bank <= ba;
         if (act_go)                             out_row  <= addr[ROW_W-1:0];
         if (rd_go || wr_go)                     out_col  <= addr[COL_W-1:0];
         if (lcr_go)                             out_code <= addr[CODE_W-1:0];
      end
   end

   a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_strobe));

   a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke || cs_n) |=> (cmd_strobe == '0 && !illegal_cmd && !wr_reject && !mrd_err));

   a_r3_idle_banks_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke || cs_n) |=> $stable(bank_open));

   a_r5_closed_read: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_RD && !bank_open[ba]) |=> (illegal_cmd && !cmd_strobe[S_RD]));

   a_r6_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_WR && !prog_setup_done) |=> (wr_reject && !cmd_strobe[S_WR]));

   a_r8_load_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_load_en |=> !cmd_strobe[S_LCR]);

endmodule

// File: tb/test_sfl_cmd_front.sv
`timescale 1ns/1ps
module test_sfl_cmd_front;

   localparam int GAP = 2;
   localparam logic [10:0] MDEF = 11'h023;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic        dqm = 1'b1;
   logic        cmd_load_en = 1'b0, prog_setup_done = 1'b0;

   logic [6:0]  cmd_strobe;
   logic        illegal_cmd, wr_reject, mrd_err;
   logic [3:0]  bank_open;
   logic [10:0] mode_reg;
   logic [1:0]  out_bank;
   logic [11:0] out_row;
   logic [7:0]  out_col, out_code;
   logic        dq_wr_en, dq_rd_oe;

   sfl_cmd_front #(.MRD_GAP(GAP), .MODE_DEFAULT(MDEF)) i_sfl_cmd_front (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
      .cmd_load_en(cmd_load_en), .prog_setup_done(prog_setup_done),
      .cmd_strobe(cmd_strobe), .illegal_cmd(illegal_cmd), .wr_reject(wr_reject),
      .mrd_err(mrd_err), .bank_open(bank_open), .mode_reg(mode_reg),
      .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
      .out_code(out_code), .dq_wr_en(dq_wr_en), .dq_rd_oe(dq_rd_oe)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model state
   logic [6:0]  e_strobe;
   logic        e_ill, e_rej, e_merr;
   logic [3:0]  e_open = '0;
   logic [10:0] e_mode = MDEF;
   logic [1:0]  e_bank = '0;
   logic [11:0] e_row = '0;
   logic [7:0]  e_col = '0, e_code = '0;
   int          since_lmr = 1000;
   logic        prev_dqm = 1'b1;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "strobe", 32'(cmd_strobe), 32'(e_strobe));
      chk("R5", "illegal", 32'(illegal_cmd), 32'(e_ill));
      chk("R6", "wr_reject", 32'(wr_reject), 32'(e_rej));
      chk("R9", "mrd_err", 32'(mrd_err), 32'(e_merr));
      chk("R7", "bank_open", 32'(bank_open), 32'(e_open));
      chk("R9", "mode", 32'(mode_reg), 32'(e_mode));
      chk("R4", "bank/row", 32'({out_bank, out_row}), 32'({e_bank, e_row}));
      chk("R8", "col/code", 32'({out_col, out_code}), 32'({e_col, e_code}));
      chk("R10", "wr_en", 32'(dq_wr_en), 32'(!dqm));
      chk("R11", "rd_oe", 32'(dq_rd_oe), 32'(!prev_dqm));
   endtask

   // drive at negedge, model at posedge, check at next negedge
   task automatic step(input logic k, input logic [3:0] pins, input logic [1:0] b,
                       input logic [11:0] a, input logic m, input string req);
      logic [2:0] code;
      logic cur_dqm;
      cke = k; {cs_n, ras_n, cas_n, we_n} = pins; ba = b; addr = a; dqm = m;
      @(posedge clk);
      cur_dqm = m;
      e_strobe = '0; e_ill = 1'b0; e_rej = 1'b0; e_merr = 1'b0;
      code = pins[2:0];
      if (k && !pins[3]) begin
         case (code)
            3'b011: begin e_strobe[0] = 1'b1; e_open[b] = 1'b1; e_bank = b; e_row = a; end
            3'b101: if (e_open[b]) begin e_strobe[1] = 1'b1; e_bank = b; e_col = a[7:0]; end
                    else e_ill = 1'b1;
            3'b100: begin
               if (!e_open[b]) e_ill = 1'b1;
               if (!prog_setup_done) e_rej = 1'b1;
               if (e_open[b] && prog_setup_done) begin
                  e_strobe[2] = 1'b1; e_bank = b; e_col = a[7:0];
               end
            end
            3'b110: if (e_open[b]) begin e_strobe[3] = 1'b1; e_bank = b; end
                    else e_ill = 1'b1;
            3'b010: begin
               e_strobe[4] = 1'b1;
               if (a[10]) e_open = '0; else e_open[b] = 1'b0;
            end
            3'b001: if (cmd_load_en) begin e_strobe[5] = 1'b1; e_code = a[7:0]; end
            3'b000: if (since_lmr >= GAP) begin
                       e_strobe[6] = 1'b1; e_mode = a[10:0]; since_lmr = 0;
                    end else e_merr = 1'b1;
            default: ;
         endcase
      end
      if (since_lmr < 1000) since_lmr++;
      @(negedge clk);
      check_all(req);
      prev_dqm = cur_dqm;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state while held and after release
      chk("R1", "strobe in reset", 32'(cmd_strobe), 0);
      chk("R1", "banks in reset", 32'(bank_open), 0);
      chk("R1", "mode default", 32'(mode_reg), 32'(MDEF));
      chk("R1", "rd_oe in reset", 32'(dq_rd_oe), 0);
      rst_n = 1'b1;
      e_strobe = '0; e_ill = 0; e_rej = 0; e_merr = 0;
      @(negedge clk);
      check_all("R1");

      // R9: back-to-back mode loads, then spaced
      step(1'b1, 4'b0000, 2'd0, 12'h5A5, 1'b0, "R9");
      step(1'b1, 4'b0000, 2'd0, 12'h0F0, 1'b1, "R9");
      step(1'b1, 4'b0000, 2'd0, 12'h3C3, 1'b0, "R9");
      step(1'b1, 4'b0111, 2'd0, 12'h000, 1'b1, "R2");
      step(1'b1, 4'b0000, 2'd0, 12'h7FF, 1'b1, "R9");

      // R4/R7: open all, close one, close all with bank bits ignored
      for (int b = 0; b < 4; b++) step(1'b1, 4'b0011, 2'(b), 12'(b * 291 + 7), 1'b0, "R4");
      step(1'b1, 4'b0010, 2'd2, 12'h000, 1'b0, "R7");
      step(1'b1, 4'b0010, 2'd2, 12'h400, 1'b0, "R7");

      // sweep: command-load enable, setup, clock enable, bank rotation, all pin codes
      for (int lc = 0; lc < 2; lc++) begin
         for (int su = 0; su < 2; su++) begin
            for (int ck = 1; ck >= 0; ck--) begin
               for (int rep = 0; rep < 8; rep++) begin
                  for (int c = 0; c < 16; c++) begin
                     int i;
                     i = ((lc * 2 + su) * 2 + ck) * 128 + rep * 16 + c;
                     cmd_load_en = lc[0];
                     prog_setup_done = su[0];
                     step(ck[0], 4'(c), 2'((rep + c) % 4), 12'((i * 1237 + 5) % 4096),
                          ((i * 7) >> 2) & 1 ? 1'b1 : 1'b0,
                          ck == 0 ? "R3" : (c >= 8 ? "R3" : "R2"));
                  end
               end
            end
         end
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule